// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block carries out one whole SMBus transaction on behalf of a host. It does so by commanding a byte-level I2C master engine that sits beside it. The host hands over one request: a 7-bit target address, a direction flag, a command byte and a transfer type (quick, byte, byte-data, word-data or block-data). The sequencer then works out how many data bytes to move. It issues start, repeated-start and stop requests to the engine, and it loads bytes for transmission. It steers the engine's acknowledge control and writes received bytes into the host's data buffer.

The sequencer moves forward only when the engine raises an event strobe: data-ready, bus error or negative acknowledge. Every transaction ends with a one-cycle `done` pulse and a result code. The codes are success, no device, I/O error and invalid request. A reset-needed flag tells the host whether the engine should be reinitialised before the next transfer. Bit timing on the wires, clock stretching and arbitration between masters all belong to the engine.

Top module: `smbus_txn_seq`

## Requirements
- R1: The address byte loaded into the engine is `{addr[6:0], dir}`, where dir 1 means read. When the direction is forced to write, bit 0 is 0.
- R2: `req_ready` is high only while the sequencer is idle. An accepted, valid request produces an `eng_start` pulse in the cycle after the handshake, and `req_ready` is low from then until the transaction ends.
- R3: The type codes are quick=0, byte=1, byte-data=2, word-data=3 and block-data=4. For quick and byte, the first data-ready loads the address with its real direction bit. For the other types, the first data-ready loads the address forced to write, and the next one loads the command byte.
- R4: For a read of type 2, 3 or 4, the data-ready that follows the command byte produces an `eng_start` pulse (repeated start) together with a load of the address with the read bit.
- R5: `eng_nack_ctl` is updated each time the read address is loaded: it is set when exactly one byte is to be received and cleared otherwise. At each received byte it is set when two bytes remained before that byte, and cleared otherwise.
- R6: Every byte moved decrements the remaining count. A read completes on its last received byte. A write completes on the data-ready that follows its last transmitted byte, which for quick write is the one that follows the address. Completion gives `eng_stop`, `done` and result 0 (success) with reset-needed 0. `eng_stop` and `eng_tx_valid` never pulse together.
- R7: Only the three event strobes advance the sequencer. A change of `eng_master` or `eng_rx_byte` alone produces no output pulse.
- R8: A negative acknowledge while busy produces `eng_stop`, `eng_clr_flags` and `done` in the same cycle, with result 1 (no device) and reset-needed 0.
- R9: A bus error while busy, or any event that arrives while `eng_master` is low, ends the transaction with `done`, result 2 (I/O error) and reset-needed 1. No stop is requested.
- R10: A busy sequencer that sees no event for `TIMEOUT_CYC` cycles ends with `done`, result 2 and reset-needed 1. `done` comes exactly `TIMEOUT_CYC` cycles after the start pulse when no event arrives.
- R11: Three kinds of request are rejected one cycle after the handshake: a read whose byte count is zero (quick read, or block read whose buffer element 0 is 0), and any type code above 4. A rejected request gives `done` with result 3, reset-needed 0, and no engine activity.
- R12: The byte type transmits the command byte as its single data byte. Word-data moves buffer elements 0 then 1 (low byte first). Block-data takes its byte count from buffer element 0 and moves elements 1 onward.
- R13: An event strobe seen while idle produces no output pulse and sets `spurious`. `spurious` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_addr | input | 7 | Target address |
| req_rd | input | 1 | Direction, 1 = read |
| req_cmd | input | 8 | Command byte |
| req_kind | input | 3 | Transfer type code |
| buf_ridx | output | LEN_W+1 | Buffer read index |
| buf_rdata | input | 8 | Buffer element at buf_ridx (combinational read) |
| buf_we | output | 1 | Buffer write strobe for a received byte |
| buf_widx | output | LEN_W+1 | Buffer write index |
| buf_wdata | output | 8 | Received byte |
| eng_start | output | 1 | Start or repeated-start request pulse |
| eng_stop | output | 1 | Stop request pulse |
| eng_clr_flags | output | 1 | Clear engine NACK and stall status pulse |
| eng_tx_valid | output | 1 | Load eng_tx_byte into the engine |
| eng_tx_byte | output | 8 | Byte to transmit |
| eng_nack_ctl | output | 1 | Withhold acknowledge on next received byte |
| eng_data_ready | input | 1 | Engine ready for next byte (event strobe) |
| eng_bus_err | input | 1 | Bus error (event strobe) |
| eng_nack | input | 1 | Negative acknowledge seen (event strobe) |
| eng_master | input | 1 | Engine currently owns the bus |
| eng_rx_byte | input | 8 | Byte just received by the engine |
| done | output | 1 | Transaction finished pulse |
| result | output | 2 | 0 success, 1 no device, 2 I/O error, 3 invalid |
| reset_needed | output | 1 | Engine must be reinitialised |
| spurious | output | 1 | Sticky: an event arrived while idle |

## Verification
Every output of this block is registered. Each pulse answering an event strobe or a request handshake is therefore due in exactly the cycle after that stimulus. The one exception is the timeout, which closes `TIMEOUT_CYC` cycles after the start pulse. Each expected item carries no time of its own. The monitor instead compares the cycle in which the item appears with the cycle in which the driver last applied a stimulus, plus one, so an early or late pulse fails even when its value is right. For the timeout case, the monitor records the start and done cycles and checks their exact distance.

// File: rtl/smbus_seq_pkg.sv
`timescale 1ns/1ps
package smbus_seq_pkg;

    typedef enum logic [2:0] {
        K_QUICK = 3'd0,
        K_BYTE  = 3'd1,
        K_BDATA = 3'd2,
        K_WORD  = 3'd3,
        K_BLOCK = 3'd4
    } xfer_kind_e;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_NODEV = 2'd1,
        RES_IOERR = 2'd2,
        RES_INVAL = 2'd3
    } result_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_QUICK,
        S_ADDR,
        S_CMD,
        S_RSTART,
        S_READ,
        S_WRITE
    } seq_state_e;

endpackage

// File: rtl/smbus_seq_plan.sv
`timescale 1ns/1ps
module smbus_seq_plan
    import smbus_seq_pkg::*;
#(
    parameter int unsigned LEN_W = 8,
    parameter int unsigned IDX_W = LEN_W + 1
) (
    input  logic [2:0]       kind,
    input  logic             rd,
    input  logic [7:0]       first_elem,
    output logic [LEN_W-1:0] len,
    output logic [IDX_W-1:0] idx0,
    output logic             direct_addr,
    output logic             reject
);
    logic bad_kind;

    always_comb begin
        len         = '0;
        idx0        = '0;
        direct_addr = 1'b0;
        bad_kind    = 1'b0;
        if (kind == K_QUICK) begin
            direct_addr = 1'b1;
        end else if (kind == K_BYTE) begin
            direct_addr = 1'b1;
            len         = LEN_W'(1);
        end else if (kind == K_BDATA) begin
            len = LEN_W'(1);
        end else if (kind == K_WORD) begin
            len = LEN_W'(2);
        end else if (kind == K_BLOCK) begin
            len  = LEN_W'(first_elem);
            idx0 = IDX_W'(1);
        end else begin
            bad_kind = 1'b1;
        end
        reject = bad_kind || (rd && (len == '0));
    end
endmodule

// File: rtl/smbus_seq_timer.sv
`timescale 1ns/1ps
module smbus_seq_timer #(
    parameter int unsigned LIMIT = 40_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && !clr && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run && !expired)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/smbus_txn_seq.sv
`timescale 1ns/1ps
module smbus_txn_seq
    import smbus_seq_pkg::*;
#(
    parameter int unsigned LEN_W       = 8,
    parameter int unsigned TIMEOUT_CYC = 40_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [6:0]       req_addr,
    input  logic             req_rd,
    input  logic [7:0]       req_cmd,
    input  logic [2:0]       req_kind,
    output logic [LEN_W:0]   buf_ridx,
    input  logic [7:0]       buf_rdata,
    output logic             buf_we,
    output logic [LEN_W:0]   buf_widx,
    output logic [7:0]       buf_wdata,
    output logic             eng_start,
    output logic             eng_stop,
    output logic             eng_clr_flags,
    output logic             eng_tx_valid,
    output logic [7:0]       eng_tx_byte,
    output logic             eng_nack_ctl,
    input  logic             eng_data_ready,
    input  logic             eng_bus_err,
    input  logic             eng_nack,
    input  logic             eng_master,
    input  logic [7:0]       eng_rx_byte,
    output logic             done,
    output logic [1:0]       result,
    output logic             reset_needed,
    output logic             spurious
);
    localparam int unsigned IDX_W = LEN_W + 1;

    typedef struct packed {
        seq_state_e       st;
        logic [7:0]       abyte;
        logic [7:0]       cmd;
        logic [2:0]       kind;
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] idx;
        logic             start;
        logic             stop;
        logic             clr;
        logic             txv;
        logic [7:0]       txb;
        logic             ackc;
        logic             we;
        logic [IDX_W-1:0] widx;
        logic [7:0]       wdata;
        logic             done;
        logic [1:0]       res;
        logic             rstn;
        logic             spur;
    } seq_regs_t;

    seq_regs_t n, q;

    logic             evt, busy, tmo_hit;
    logic [LEN_W-1:0] plan_len;
    logic [IDX_W-1:0] plan_idx0;
    logic             plan_direct, plan_reject;

    assign evt  = eng_data_ready || eng_bus_err || eng_nack;
    assign busy = (q.st != S_IDLE);

    smbus_seq_plan #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_plan (
        .kind        (req_kind),
        .rd          (req_rd),
        .first_elem  (buf_rdata),
        .len         (plan_len),
        .idx0        (plan_idx0),
        .direct_addr (plan_direct),
        .reject      (plan_reject)
    );

    smbus_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!busy || evt),
        .run     (busy),
        .expired (tmo_hit)
    );

    function automatic seq_regs_t close_txn(seq_regs_t s, logic [1:0] code, logic rn);
        seq_regs_t r;
        r      = s;
        r.st   = S_IDLE;
        r.idx  = '0;
        r.done = 1'b1;
        r.res  = code;
        r.rstn = rn;
        return r;
    endfunction

    always_comb begin
        n       = q;
        n.start = 1'b0;
        n.stop  = 1'b0;
        n.clr   = 1'b0;
        n.txv   = 1'b0;
        n.we    = 1'b0;
        n.done  = 1'b0;
        if (!busy) begin
            if (evt) n.spur = 1'b1;
            if (req_valid) begin
                n.abyte = {req_addr, req_rd};
                n.cmd   = req_cmd;
                n.kind  = req_kind;
                if (plan_reject) begin
                    n = close_txn(n, RES_INVAL, 1'b0);
                end else begin
                    n.start = 1'b1;
                    n.len   = plan_len;
                    n.idx   = plan_idx0;
                    n.st    = plan_direct ? S_QUICK : S_ADDR;
                end
            end
        end else if (evt) begin
            if (eng_bus_err || !eng_master) begin
                n = close_txn(n, RES_IOERR, 1'b1);
            end else if (eng_nack) begin
                n.stop = 1'b1;
                n.clr  = 1'b1;
                n      = close_txn(n, RES_NODEV, 1'b0);
            end else begin
                unique case (q.st)
                    S_QUICK, S_RSTART: begin
                        n.start = (q.st == S_RSTART);
                        n.txv   = 1'b1;
                        n.txb   = q.abyte;
                        if (q.abyte[0]) begin
                            n.ackc = (q.len == LEN_W'(1));
                            n.st   = S_READ;
                        end else begin
                            n.st = S_WRITE;
                        end
                    end
                    S_ADDR: begin
                        n.txv = 1'b1;
                        n.txb = {q.abyte[7:1], 1'b0};
                        n.st  = S_CMD;
                    end
                    S_CMD: begin
                        n.txv = 1'b1;
                        n.txb = q.cmd;
                        n.st  = q.abyte[0] ? S_RSTART : S_WRITE;
                    end
                    S_READ: begin
                        n.ackc  = (q.len == LEN_W'(2));
                        n.we    = 1'b1;
                        n.widx  = q.idx;
                        n.wdata = eng_rx_byte;
                        n.idx   = q.idx + IDX_W'(1);
                        n.len   = q.len - LEN_W'(1);
                        if (q.len == LEN_W'(1)) begin
                            n.stop = 1'b1;
                            n      = close_txn(n, RES_OK, 1'b0);
                        end
                    end
                    S_WRITE: begin
                        if (q.len == '0) begin
                            n.stop = 1'b1;
                            n      = close_txn(n, RES_OK, 1'b0);
                        end else begin
                            n.txv = 1'b1;
                            n.txb = (q.kind == K_BYTE) ? q.cmd : buf_rdata;
                            n.idx = q.idx + IDX_W'(1);
                            n.len = q.len - LEN_W'(1);
                        end
                    end
                    default: n = close_txn(n, RES_IOERR, 1'b1);
                endcase
            end
        end else if (tmo_hit) begin
            n = close_txn(n, RES_IOERR, 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign req_ready     = !busy;
    assign buf_ridx      = q.idx;
    assign buf_we        = q.we;
    assign buf_widx      = q.widx;
    assign buf_wdata     = q.wdata;
    assign eng_start     = q.start;
    assign eng_stop      = q.stop;
    assign eng_clr_flags = q.clr;
    assign eng_tx_valid  = q.txv;
    assign eng_tx_byte   = q.txb;
    assign eng_nack_ctl  = q.ackc;
    assign done          = q.done;
    assign result        = q.res;
    assign reset_needed  = q.rstn;
    assign spurious      = q.spur;

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !plan_reject) |=> (eng_start && !req_ready));

    // R6
    stop_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_stop && eng_tx_valid));

    // R8
    nack_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_nack && !eng_bus_err && eng_master)
        |=> (eng_stop && eng_clr_flags && done && result == RES_NODEV && !reset_needed));

    // R9
    fault_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (eng_bus_err || (evt && !eng_master)))
        |=> (done && result == RES_IOERR && reset_needed && !eng_stop));

    // R11
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && plan_reject)
        |=> (done && result == RES_INVAL && !eng_start && !reset_needed));

    // R13
    spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && evt) |=> spurious);
endmodule

// File: tb/sim_smbus_txn_seq.sv
`timescale 1ns/1ps
module sim_smbus_txn_seq;
    localparam int TMO = 300;
    localparam int KQ = 0, KB = 1, KBD = 2, KW = 3, KBL = 4;
    localparam int T_START = 0, T_TX = 1, T_WR = 2, T_STOP = 3, T_CLR = 4, T_DONE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_rd = 1'b0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_cmd = '0;
    logic [2:0] req_kind = '0;
    logic [8:0] buf_ridx, buf_widx;
    logic [7:0] buf_rdata, buf_wdata, eng_tx_byte;
    logic buf_we, eng_start, eng_stop, eng_clr_flags, eng_tx_valid, eng_nack_ctl;
    logic eng_data_ready = 1'b0, eng_bus_err = 1'b0, eng_nack = 1'b0, eng_master = 1'b1;
    logic [7:0] eng_rx_byte = '0;
    logic done, reset_needed, spurious;
    logic [1:0] result;

    logic [7:0] bufm [0:63];
    assign buf_rdata = bufm[buf_ridx[5:0]];

    always #2.5 clk = ~clk;

    smbus_txn_seq #(.LEN_W(8), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_rd(req_rd), .req_cmd(req_cmd), .req_kind(req_kind),
        .buf_ridx(buf_ridx), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_widx(buf_widx),
        .buf_wdata(buf_wdata), .eng_start(eng_start), .eng_stop(eng_stop),
        .eng_clr_flags(eng_clr_flags), .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
        .eng_nack_ctl(eng_nack_ctl), .eng_data_ready(eng_data_ready), .eng_bus_err(eng_bus_err),
        .eng_nack(eng_nack), .eng_master(eng_master), .eng_rx_byte(eng_rx_byte),
        .done(done), .result(result), .reset_needed(reset_needed), .spurious(spurious)
    );

    typedef struct {
        int          tag;
        logic [31:0] data;
        logic [31:0] mask;
        string       rq;
    } item_t;

    item_t q[$];
    int checks = 0, errors = 0;
    int cyc = 0, stim_cyc = 0, t_start = 0, t_done = 0;
    bit tmo_mode = 1'b0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void push(int tag, logic [31:0] d, logic [31:0] m, string rq);
        item_t it;
        it.tag = tag; it.data = d; it.mask = m; it.rq = rq;
        q.push_back(it);
    endfunction

    task automatic take(int tag, logic [31:0] act);
        item_t it;
        checks++;
        if (q.size() == 0) begin
            errors++;
            $display("FAIL R7 unexpected output tag %0d actual %h expected none", tag, act);
        end else begin
            it = q.pop_front();
            if (it.tag != tag || ((act ^ it.data) & it.mask) != 0 ||
                (!tmo_mode && cyc != stim_cyc + 1)) begin
                errors++;
                $display("FAIL %s tag %0d actual %h cycle %0d expected tag %0d %h cycle %0d",
                         it.rq, tag, act & it.mask, cyc, it.tag, it.data, stim_cyc + 1);
            end
            if (tag == T_START) t_start = cyc;
            if (tag == T_DONE)  t_done  = cyc;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (eng_start)     take(T_START, 32'd0);
            if (eng_tx_valid)  take(T_TX, {23'd0, eng_nack_ctl, eng_tx_byte});
            if (buf_we)        take(T_WR, {14'd0, eng_nack_ctl, buf_widx, buf_wdata});
            if (eng_stop)      take(T_STOP, 32'd0);
            if (eng_clr_flags) take(T_CLR, 32'd0);
            if (done)          take(T_DONE, {29'd0, reset_needed, result});
        end
    end

    task automatic chk(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic send_req(int kind, bit rd, logic [6:0] addr, logic [7:0] cmd);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(kind); req_rd = rd; req_addr = addr; req_cmd = cmd;
        stim_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_evt(bit dr, bit be, bit nk, bit ms, logic [7:0] rx);
        @(negedge clk);
        eng_data_ready = dr; eng_bus_err = be; eng_nack = nk; eng_master = ms; eng_rx_byte = rx;
        stim_cyc = cyc;
        @(negedge clk);
        eng_data_ready = 1'b0; eng_bus_err = 1'b0; eng_nack = 1'b0; eng_master = 1'b1;
        @(negedge clk);
    endtask

    task automatic drain(int limit, string rq);
        for (int i = 0; i < limit && q.size() != 0; i++) @(negedge clk);
        chk(q.size() == 0, rq, q.size(), 0);
        q.delete();
        repeat (2) @(negedge clk);
    endtask

    task automatic push_done(bit rn, int code, string rq);
        push(T_DONE, {29'd0, rn, 2'(code)}, 32'h7, rq);
    endtask

    // Full transaction from the requirements; noise adds non-event activity mid-way (R7)
    task automatic do_txn(int kind, bit rd, logic [6:0] addr, logic [7:0] cmd, bit noise);
        int len, base;
        base = (kind == KBL) ? 1 : 0;
        case (kind)
            KQ: len = 0;
            KB, KBD: len = 1;
            KW: len = 2;
            KBL: len = int'(bufm[0]);
            default: len = 0;
        endcase
        if (kind > 4 || (rd && len == 0)) begin
            push_done(1'b0, 3, "R11");
            send_req(kind, rd, addr, cmd);
            drain(20, "R11");
            return;
        end
        push(T_START, 0, 0, "R2");
        send_req(kind, rd, addr, cmd);
        if (kind <= KB) begin
            push(T_TX, {23'd0, (rd && len == 1), addr, rd}, rd ? 32'h1FF : 32'hFF, "R3");
            pulse_evt(1, 0, 0, 1, 8'h00);
        end else begin
            push(T_TX, {24'd0, addr, 1'b0}, 32'hFF, "R1");
            pulse_evt(1, 0, 0, 1, 8'h00);
            push(T_TX, {24'd0, cmd}, 32'hFF, "R3");
            pulse_evt(1, 0, 0, 1, 8'h00);
            if (rd) begin
                push(T_START, 0, 0, "R4");
                push(T_TX, {23'd0, (len == 1), addr, 1'b1}, 32'h1FF, "R4");
                pulse_evt(1, 0, 0, 1, 8'h00);
            end
        end
        if (noise) begin
            @(negedge clk);
            eng_master = 1'b0; eng_rx_byte = 8'hFF;
            repeat (3) @(negedge clk);
            chk(!done && !req_ready, "R7", int'(done), 0);
            chk(!req_ready, "R2", int'(req_ready), 0);
            eng_master = 1'b1;
        end
        if (rd) begin
            for (int i = 0; i < len; i++) begin
                logic [7:0] rx;
                rx = 8'(i * 29 + int'(addr) + 7);
                push(T_WR, {14'd0, (len - i == 2), 9'(base + i), rx}, 32'h3FFFF,
                     (kind >= KW) ? "R12" : "R5");
                if (i == len - 1) begin
                    push(T_STOP, 0, 0, "R6");
                    push_done(1'b0, 0, "R6");
                end
                pulse_evt(1, 0, 0, 1, rx);
            end
        end else begin
            for (int i = 0; i < len; i++) begin
                push(T_TX, {24'd0, (kind == KB) ? cmd : bufm[base + i]}, 32'hFF,
                     (kind == KB || kind >= KW) ? "R12" : "R6");
                pulse_evt(1, 0, 0, 1, 8'h00);
            end
            push(T_STOP, 0, 0, "R6");
            push_done(1'b0, 0, "R6");
            pulse_evt(1, 0, 0, 1, 8'h00);
        end
        drain(20, "R6");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) bufm[i] = 8'(i * 13 + 5);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(req_ready == 1'b1, "R2", int'(req_ready), 1);
        chk(done == 1'b0 && reset_needed == 1'b0, "R6", int'(done), 0);
        chk(spurious == 1'b0, "R13", int'(spurious), 0);
        chk(eng_nack_ctl == 1'b0, "R5", int'(eng_nack_ctl), 0);

        // event while idle
        pulse_evt(1, 0, 0, 1, 8'h11);
        chk(spurious == 1'b1, "R13", int'(spurious), 1);
        chk(req_ready == 1'b1, "R13", int'(req_ready), 1);

        do_txn(KQ, 0, 7'h21, 8'h00, 0);
        do_txn(KB, 1, 7'h2C, 8'h00, 0);
        do_txn(KB, 0, 7'h3A, 8'h9E, 0);
        do_txn(KBD, 1, 7'h48, 8'h12, 0);
        do_txn(KBD, 0, 7'h55, 8'h34, 1);
        do_txn(KW, 1, 7'h61, 8'h56, 0);
        do_txn(KW, 0, 7'h0F, 8'h78, 0);
        bufm[0] = 8'd3;
        do_txn(KBL, 1, 7'h70, 8'hA1, 0);
        bufm[0] = 8'd2;
        do_txn(KBL, 0, 7'h71, 8'hA2, 0);

        // rejected requests: R11
        do_txn(KQ, 1, 7'h22, 8'h00, 0);
        bufm[0] = 8'd0;
        do_txn(KBL, 1, 7'h23, 8'h01, 0);
        do_txn(7, 0, 7'h24, 8'h02, 0);
        bufm[0] = 8'd2;

        // R8 negative acknowledge after the address byte
        push(T_START, 0, 0, "R2");
        send_req(KBD, 0, 7'h50, 8'h10);
        push(T_TX, {24'd0, 7'h50, 1'b0}, 32'hFF, "R1");
        pulse_evt(1, 0, 0, 1, 8'h00);
        push(T_STOP, 0, 0, "R8");
        push(T_CLR, 0, 0, "R8");
        push_done(1'b0, 1, "R8");
        pulse_evt(0, 0, 1, 1, 8'h00);
        drain(20, "R8");

        // R9 bus error
        push(T_START, 0, 0, "R2");
        send_req(KBL, 0, 7'h33, 8'h20);
        push(T_TX, {24'd0, 7'h33, 1'b0}, 32'hFF, "R1");
        pulse_evt(1, 0, 0, 1, 8'h00);
        push_done(1'b1, 2, "R9");
        pulse_evt(0, 1, 0, 1, 8'h00);
        drain(20, "R9");

        // R9 lost master on data-ready
        push(T_START, 0, 0, "R2");
        send_req(KW, 1, 7'h44, 8'h30);
        push(T_TX, {24'd0, 7'h44, 1'b0}, 32'hFF, "R1");
        pulse_evt(1, 0, 0, 1, 8'h00);
        push(T_TX, {24'd0, 8'h30}, 32'hFF, "R3");
        pulse_evt(1, 0, 0, 1, 8'h00);
        push_done(1'b1, 2, "R9");
        pulse_evt(1, 0, 0, 0, 8'h00);
        drain(20, "R9");

        // R10 timeout with no event
        push(T_START, 0, 0, "R2");
        send_req(KB, 0, 7'h19, 8'h40);
        drain(20, "R2");
        tmo_mode = 1'b1;
        push_done(1'b1, 2, "R10");
        drain(TMO + 40, "R10");
        tmo_mode = 1'b0;
        chk(t_done - t_start == TMO, "R10", t_done - t_start, TMO);
        chk(req_ready == 1'b1, "R10", int'(req_ready), 1);

        // sticky flag survives transactions
        chk(spurious == 1'b1, "R13", int'(spurious), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule